// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller with Spurious Vector

This block collects eight interrupt request lines, latches rising edges into a request register, and filters them through a mask register and an in-service register under a fixed priority scheme. When an unmasked request outranks everything currently in service, the controller raises `intr` toward the processor. The processor answers with a one-cycle `inta` pulse. The controller then returns an 8-bit vector built from a programmable base and the winning level number, and marks that level as in service.

If the request that raised `intr` has disappeared by the time `inta` arrives, the controller still answers. It returns the vector for line 7, the lowest-priority line, and leaves the in-service register untouched. Software can therefore tell a spurious line-7 interrupt from a genuine one by reading the in-service register. A small register bus provides access to the controller: one address bit, a write strobe and a read strobe. Through it software writes the mask, loads the vector base, selects whether command-port reads return the request or the in-service register, and issues specific or non-specific end-of-interrupt commands.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `intr` is 0, the mask, request and in-service registers are all 0, command-port reads return the request register, and the vector base is 0.
- R2: A request bit is set by a rising edge on its line. It is cleared when the line is low or when that level is granted. A line held high after its grant does not request again.
- R3: A write to the data port (`bus_addr`=1) loads the mask register, and a read of the data port returns it. A set mask bit stops its line from raising `intr`.
- R4: Line 0 has the highest priority and line 7 the lowest. On a granted acknowledge, the highest-priority eligible request wins, its request bit clears and its in-service bit sets.
- R5: `intr` is high only when an unmasked pending request has priority strictly higher than every set in-service bit.
- R6: The vector is {base[7:3], level[2:0]}. A command-port write with bit 4 set arms a base load. The next data-port write then loads the base instead of the mask and leaves the mask unchanged.
- R7: An acknowledge that finds no eligible request returns {base[7:3], 3'b111} and leaves the in-service register unchanged. This holds whatever the mask register contains.
- R8: A genuine line-7 acknowledge returns the same vector as a spurious one and sets in-service bit 7.
- R9: Command byte 0x03 makes later command-port reads return the in-service register. Command byte 0x02 makes them return the request register.
- R10: Command byte 0x20 clears the highest-priority in-service bit that is set.
- R11: Command byte 0x60 OR'd with a level n (0..7) clears in-service bit n only.
- R12: `vec_vld` is high for exactly the one cycle after an `inta` cycle. `vec` holds its value until the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Interrupt request lines, bit n is level n |
| bus_addr | input | 1 | 0 selects the command port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is 0 when this is low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| intr | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |
| vec | output | 8 | Vector returned for the last acknowledge |
| vec_vld | output | 1 | One-cycle strobe after each acknowledge |

## Verification
The bench goes after the spurious path from two sides. In the first, a line pulses and drops before the acknowledge. A design that kept the stale request would return that line's vector and set its in-service bit. In the second, the acknowledge arrives while every line is masked. A design that honoured the mask in the spurious path would return garbage or set bit 7. Against each spurious case the bench runs a genuine line-7 request, which must return the identical vector but with bit 7 set.

The bench also sweeps all 28 pairs of simultaneous requests, nested grants and both kinds of end-of-interrupt. An inverted priority encoder would return the wrong winner. A `<=` in place of a strict comparison would let an equal level nest. A specific end-of-interrupt that clears too much would lose the other in-service bits.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [0:0] {
        CMD_IDLE      = 1'b0,
        CMD_BASE_WAIT = 1'b1
    } cmd_state_t;

    localparam logic [7:0] CMD_SEL_REQ  = 8'h02;
    localparam logic [7:0] CMD_SEL_SVC  = 8'h03;
    localparam logic [7:0] CMD_EOI_TOP  = 8'h20;
    localparam logic [4:0] CMD_EOI_LVL  = 5'b01100;
    localparam int         CMD_BASE_BIT = 4;

endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] grant_clr,
    output logic [N_LINES-1:0] req
);
    logic [N_LINES-1:0] lines_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= '0;
            req     <= '0;
        end else begin
            lines_q <= lines;
            req     <= (req | (lines & ~lines_q)) & lines & ~grant_clr;
        end
    end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int N_LINES = 8,
    parameter int LVL_W   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] bits,
    output logic               found,
    output logic [LVL_W-1:0]   idx
);
    always_comb begin
        found = |bits;
        idx   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (bits[i]) idx = LVL_W'(i);
        end
    end
endmodule

// File: rtl/pic_cmd_fsm.sv
module pic_cmd_fsm
    import pic_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [7:0]       wdata,
    output logic             load_mask,
    output logic             load_base,
    output logic             eoi_top,
    output logic             eoi_lvl,
    output logic [LVL_W-1:0] eoi_sel,
    output logic             show_svc
);
    cmd_state_t state, state_n;
    logic cmd_wr, dat_wr;

    assign cmd_wr = wr && !addr;
    assign dat_wr = wr && addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CMD_IDLE;
            show_svc <= 1'b0;
        end else begin
            state <= state_n;
            if (cmd_wr && wdata == CMD_SEL_SVC) show_svc <= 1'b1;
            else if (cmd_wr && wdata == CMD_SEL_REQ) show_svc <= 1'b0;
        end
    end

    always_comb begin
        state_n   = state;
        load_mask = 1'b0;
        load_base = 1'b0;
        eoi_top   = cmd_wr && (wdata == CMD_EOI_TOP);
        eoi_lvl   = cmd_wr && (wdata[7:3] == CMD_EOI_LVL);
        eoi_sel   = wdata[LVL_W-1:0];
        unique case (state)
            CMD_IDLE: begin
                if (cmd_wr && wdata[CMD_BASE_BIT]) state_n = CMD_BASE_WAIT;
                load_mask = dat_wr;
            end
            CMD_BASE_WAIT: begin
                if (dat_wr) begin
                    load_base = 1'b1;
                    state_n   = CMD_IDLE;
                end
            end
            default: state_n = CMD_IDLE;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             intr,
    input  logic             inta,
    output logic [VEC_W-1:0] vec,
    output logic             vec_vld
);
    localparam int LVL_W  = $clog2(N_LINES);
    localparam int BASE_W = VEC_W - LVL_W;

    logic [N_LINES-1:0] req_q, mask_q, svc_q, svc_n, grant_clr, pend;
    logic [BASE_W-1:0]  base_q;
    logic               p_found, s_found, eligible, grant;
    logic [LVL_W-1:0]   p_idx, s_idx, eoi_sel;
    logic               load_mask, load_base, eoi_top, eoi_lvl, show_svc;

    pic_cmd_fsm #(.LVL_W(LVL_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .load_mask(load_mask), .load_base(load_base), .eoi_top(eoi_top),
        .eoi_lvl(eoi_lvl), .eoi_sel(eoi_sel), .show_svc(show_svc)
    );

    pic_req_latch #(.N_LINES(N_LINES)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines), .grant_clr(grant_clr), .req(req_q)
    );

    assign pend = req_q & ~mask_q;

    pic_prio_pick #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_pick_req (
        .bits(pend), .found(p_found), .idx(p_idx)
    );

    pic_prio_pick #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_pick_svc (
        .bits(svc_q), .found(s_found), .idx(s_idx)
    );

    assign eligible  = p_found && (!s_found || (p_idx < s_idx));
    assign intr      = eligible;
    assign grant     = inta && eligible;
    assign grant_clr = grant ? (N_LINES'(1) << p_idx) : '0;

    always_comb begin
        svc_n = svc_q;
        if (eoi_top && s_found) svc_n[s_idx] = 1'b0;
        if (eoi_lvl)            svc_n[eoi_sel] = 1'b0;
        if (grant)              svc_n[p_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q   <= '0;
            mask_q  <= '0;
            base_q  <= '0;
            vec     <= '0;
            vec_vld <= 1'b0;
        end else begin
            svc_q   <= svc_n;
            vec_vld <= inta;
            if (load_mask) mask_q <= bus_wdata[N_LINES-1:0];
            if (load_base) base_q <= bus_wdata[7:LVL_W];
            if (inta)      vec    <= {base_q, grant ? p_idx : {LVL_W{1'b1}}};
        end
    end

    always_comb begin
        if (!bus_rd)        bus_rdata = '0;
        else if (bus_addr)  bus_rdata = mask_q;
        else if (show_svc)  bus_rdata = svc_q;
        else                bus_rdata = req_q;
    end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int N_LINES = 8,
    parameter int LVL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inta,
    input logic               intr,
    input logic               bus_wr,
    input logic [LVL_W-1:0]   vec_lvl,
    input logic               vec_vld,
    input logic [N_LINES-1:0] svc,
    input logic [N_LINES-1:0] mask
);
    // R7: acknowledge without an eligible request yields the lowest level
    assert_spurious_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !intr) |=> (vec_lvl == {LVL_W{1'b1}}));

    // R7: spurious acknowledge leaves in-service untouched
    assert_spurious_keeps_svc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !intr && !bus_wr) |=> $stable(svc));

    // R8: a granted acknowledge adds exactly one in-service bit
    assert_grant_sets_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && intr && !bus_wr) |=> ($countones(svc) == $countones($past(svc)) + 1));

    // R12: strobe follows acknowledge by one cycle
    assert_vld_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> vec_vld);

    assert_vld_only_after_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !inta |=> !vec_vld);

    // R3: fully masked controller never requests
    assert_full_mask_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !intr);

    // R5: nothing outranks level 0 in service
    assert_top_svc_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        svc[0] |-> !intr);
endmodule

bind prio_irq_ctrl pic_checker #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .inta(inta), .intr(intr), .bus_wr(bus_wr),
    .vec_lvl(vec[LVL_W-1:0]), .vec_vld(vec_vld), .svc(svc_q), .mask(mask_q)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_lines = '0;
    logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, inta = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, vec;
    logic       intr, vec_vld;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    localparam logic [7:0] BASE = 8'h48;

    always #5 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .intr(intr), .inta(inta), .vec(vec), .vec_vld(vec_vld)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic read_svc(output logic [7:0] d);
        wr(1'b0, 8'h03);
        rd(1'b0, d);
    endtask

    task automatic ack(output logic [7:0] v);
        logic [7:0] held;
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        v = vec;
        chk("R12 vld after inta", {7'd0, vec_vld}, 8'h01);
        held = vec;
        @(negedge clk);
        chk("R12 vld one cycle", {7'd0, vec_vld}, 8'h00);
        chk("R12 vec held", vec, held);
    endtask

    task automatic set_lines(input logic [7:0] l);
        @(negedge clk);
        irq_lines = l;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 intr", {7'd0, intr}, 8'h00);
        rd(1'b0, d); chk("R1 req read", d, 8'h00);
        rd(1'b1, d); chk("R1 mask read", d, 8'h00);
        read_svc(d); chk("R1 svc read", d, 8'h00);
        ack(v); chk("R1 base zero, R7 spurious", v, 8'h07);
        wr(1'b0, 8'h02);

        // R6 base load, mask untouched
        wr(1'b0, 8'h13);
        wr(1'b1, BASE);
        rd(1'b1, d); chk("R6 mask unchanged by base", d, 8'h00);

        // single-line sweep: R2 R4 R6 R8 R9 R11
        for (int i = 0; i < 8; i++) begin
            set_lines(8'(1) << i);
            chk("R2 edge raises intr", {7'd0, intr}, 8'h01);
            wr(1'b0, 8'h02);
            rd(1'b0, d); chk("R9 req select", d, 8'(1) << i);
            ack(v); chk("R4 R6 vector", v, {BASE[7:3], 3'(i)});
            read_svc(d); chk("R8 svc set by grant", d, 8'(1) << i);
            wr(1'b0, 8'h02);
            rd(1'b0, d); chk("R4 req cleared", d, 8'h00);
            wr(1'b0, 8'h60 | 8'(i));
            read_svc(d); chk("R11 specific eoi", d, 8'h00);
            chk("R2 held line no rerequest", {7'd0, intr}, 8'h00);
            set_lines(8'h00);
        end

        // pair sweep: R4 R5 R10
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                set_lines((8'(1) << a) | (8'(1) << b));
                ack(v); chk("R4 winner", v, {BASE[7:3], 3'(a)});
                chk("R5 lower blocked", {7'd0, intr}, 8'h00);
                wr(1'b0, 8'h20);
                chk("R5 released after eoi", {7'd0, intr}, 8'h01);
                ack(v); chk("R4 second", v, {BASE[7:3], 3'(b)});
                wr(1'b0, 8'h20);
                read_svc(d); chk("R10 eoi clears", d, 8'h00);
                set_lines(8'h00);
            end
        end

        // nesting: R5 R10
        set_lines(8'h20);
        ack(v); chk("R4 level5", v, {BASE[7:3], 3'd5});
        set_lines(8'h24);
        chk("R5 higher nests", {7'd0, intr}, 8'h01);
        ack(v); chk("R5 nested vec", v, {BASE[7:3], 3'd2});
        read_svc(d); chk("R5 nested svc", d, 8'h24);
        wr(1'b0, 8'h20);
        read_svc(d); chk("R10 clears top only", d, 8'h20);
        wr(1'b0, 8'h20);
        read_svc(d); chk("R10 second eoi", d, 8'h00);
        set_lines(8'h00);

        // mask: R3 R7
        wr(1'b1, 8'hFF);
        set_lines(8'h08);
        chk("R3 masked no intr", {7'd0, intr}, 8'h00);
        rd(1'b1, d); chk("R3 mask readback", d, 8'hFF);
        ack(v); chk("R7 spurious while masked", v, {BASE[7:3], 3'd7});
        read_svc(d); chk("R7 svc unchanged masked", d, 8'h00);
        wr(1'b1, 8'h00);
        chk("R3 unmask raises", {7'd0, intr}, 8'h01);
        ack(v); chk("R3 unmasked vec", v, {BASE[7:3], 3'd3});
        wr(1'b0, 8'h63);
        set_lines(8'h00);

        // vanished request: R2 R7 vs genuine R8
        set_lines(8'h10);
        chk("R2 pulse raises intr", {7'd0, intr}, 8'h01);
        set_lines(8'h00);
        chk("R2 drop clears intr", {7'd0, intr}, 8'h00);
        ack(v); chk("R7 vanished vec", v, {BASE[7:3], 3'd7});
        read_svc(d); chk("R7 svc clear", d, 8'h00);
        set_lines(8'h80);
        ack(v); chk("R8 genuine vec", v, {BASE[7:3], 3'd7});
        read_svc(d); chk("R8 svc bit7", d, 8'h80);
        wr(1'b0, 8'h67);
        set_lines(8'h00);

        // specific eoi with several bits: R11
        set_lines(8'h40); ack(v);
        set_lines(8'h44); ack(v);
        set_lines(8'h46); ack(v);
        read_svc(d); chk("R11 setup", d, 8'h46);
        wr(1'b0, 8'h62);
        read_svc(d); chk("R11 clears bit2 only", d, 8'h42);
        wr(1'b0, 8'h66);
        read_svc(d); chk("R11 clears bit6 only", d, 8'h02);
        wr(1'b0, 8'h20);
        read_svc(d); chk("R10 last", d, 8'h00);
        set_lines(8'h00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule